// File: doc/BRIEF.md
# Voltage and Frequency Step Sequencer

This block carries out a change of operating level for a processor cluster. Level 0 is the fastest and level 3 the slowest. A level request is compared with the current level, and the block then runs an ordered series of actions. These are supply voltage writes to a regulator, a divider update and a PLL update. The divider and PLL sequencers sit outside the block and are driven through start and done pins. The regulator is driven through a request and acknowledge handshake.

The direction of the change sets the order. Speeding up raises both supplies first and then changes the clocks, dividers before the PLL. Slowing down changes the clocks first, the PLL before the dividers, and lowers the supplies last. A full PLL relock is asked for only when the fastest level is entered or left. Every other PLL change rewrites the post-scaler only. A suspend event locks the block to a chosen level and remembers where it came from. A resume event goes back to the remembered level and then unlocks.

Top module: `dvfs_order_ctrl`

## Requirements
- R1: When the target level index is lower than the current one (faster), the core supply write and then the internal supply write complete before any divider or PLL start.
- R2: When the target level index is higher (slower), both supply writes, core then internal, happen only after the divider and PLL steps have both completed.
- R3: Going faster, `div_start` precedes `pll_start`. Going slower, `pll_start` precedes `div_start`. Both carry the target level.
- R4: `pll_full` is 1 (full relock) only when going faster to level 0 or going slower from level 0. Otherwise it is 0 (post-scaler only).
- R5: `vreg_code` is in 10 mV units. Core supply (`vreg_sel`=0) for levels 0..3 is 120, 110, 100, 90. Internal supply (`vreg_sel`=1) is 110, 110, 100, 100.
- R6: A request for the current level pulses `xfer_done` one cycle after acceptance, with `xfer_err`=0 and no regulator, divider or PLL activity.
- R7: While `lock_active` is 1, a request for any level other than `lock_level` ends with `xfer_done` and `xfer_err` both 1, no activity and no level change. A request for the locked level is processed normally.
- R8: An idle `suspend_enter` with no lock active sets `lock_active`, stores the current level and moves to `lock_level`. A `suspend_enter` while already locked is ignored.
- R9: An idle `resume_exit` while locked moves to the stored level, then clears `lock_active` together with the level update. A `resume_exit` while unlocked is ignored.
- R10: Each supply write holds `vreg_req`, `vreg_sel` and `vreg_code` steady until `vreg_ack`, then drops `vreg_req` for at least one cycle. At most one of `vreg_req`, `div_start` and `pll_start` is high at a time.
- R11: After reset `cur_level` equals parameter BOOT_LEVEL (default 1), `lock_active`, `busy` and `xfer_done` are 0, and no action is pending.
- R12: `cur_level` takes the new level on the clock edge that ends the `xfer_done` cycle, and only when `xfer_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Level request, taken when idle |
| req_level | input | 2 | Requested level |
| suspend_enter | input | 1 | Suspend event, highest priority |
| resume_exit | input | 1 | Resume event |
| lock_level | input | 2 | Level applied and accepted while locked |
| busy | output | 1 | A transition is in progress |
| xfer_done | output | 1 | One-cycle end-of-transition pulse |
| xfer_err | output | 1 | Retry error, valid with xfer_done |
| cur_level | output | 2 | Current level |
| lock_active | output | 1 | Frequency lock in force |
| vreg_req | output | 1 | Regulator write request |
| vreg_sel | output | 1 | 0 = core supply, 1 = internal supply |
| vreg_code | output | 7 | Voltage in 10 mV units |
| vreg_ack | input | 1 | Regulator write accepted |
| div_start | output | 1 | Divider sequencer start pulse |
| div_level | output | 2 | Level for the divider sequencer |
| div_done | input | 1 | Divider sequencer finished |
| pll_start | output | 1 | PLL sequencer start pulse |
| pll_full | output | 1 | 1 = full relock, 0 = post-scaler only |
| pll_level | output | 2 | Level for the PLL sequencer |
| pll_done | input | 1 | PLL sequencer finished |

## Verification
The assertions assume the regulator raises `vreg_ack` only while `vreg_req` is high. They also assume each sequencer pulses its done line once per start, and only after that start. The bench's responders react only to the block's own requests and return single-cycle acknowledgements after a fixed delay. Events and requests are applied only while `busy` is low. Ignored events are checked at the ports by watching that no done pulse and no level or lock change follow.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  localparam int LVL_W = 2;
  localparam int VC_W  = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_VUP, S_CA_GO, S_CA_WAIT, S_CB_GO, S_CB_WAIT, S_VDN, S_DONE
  } st_e;

  typedef enum logic [1:0] { PH_REQ, PH_SUSP, PH_RES } ph_e;

  // core supply: 1.20 V at level 0, 0.10 V lower per level (10 mV units)
  function automatic logic [VC_W-1:0] core_code(input logic [LVL_W-1:0] l);
    return VC_W'(120 - 10 * int'(l));
  endfunction

  // internal supply: 1.10 V on the two fast levels, 1.00 V below
  function automatic logic [VC_W-1:0] int_code(input logic [LVL_W-1:0] l);
    return (int'(l) < 2) ? VC_W'(110) : VC_W'(100);
  endfunction

  // full relock only when level 0 is entered (faster) or left (slower)
  function automatic logic needs_relock(input logic faster,
                                        input logic [LVL_W-1:0] from_l,
                                        input logic [LVL_W-1:0] to_l);
    return faster ? (to_l == '0) : (from_l == '0);
  endfunction
endpackage

// File: rtl/dvfs_volt_lut.sv
module dvfs_volt_lut
  import dvfs_pkg::*;
#(
  parameter int LW = LVL_W,
  parameter int CW = VC_W
) (
  input  logic [LW-1:0] level,
  input  logic          sel_int,
  output logic [CW-1:0] code
);
  always_comb begin
    code = sel_int ? CW'(int_code(LVL_W'(level))) : CW'(core_code(LVL_W'(level)));
  end
endmodule

// File: rtl/dvfs_step_plan.sv
module dvfs_step_plan
  import dvfs_pkg::*;
#(
  parameter int LW = LVL_W
) (
  input  logic [LW-1:0] from_l,
  input  logic [LW-1:0] to_l,
  output logic          same,
  output logic          faster,
  output logic          relock
);
  always_comb begin
    same   = (from_l == to_l);
    faster = (to_l < from_l);
    relock = needs_relock(faster, LVL_W'(from_l), LVL_W'(to_l));
  end
endmodule

// File: rtl/dvfs_lock_keeper.sv
module dvfs_lock_keeper #(
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          engage,
  input  logic          release_now,
  input  logic [LW-1:0] cur_l,
  output logic          locked,
  output logic [LW-1:0] saved_l
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked  <= 1'b0;
      saved_l <= '0;
    end else if (engage) begin
      locked  <= 1'b1;
      saved_l <= cur_l;
    end else if (release_now) begin
      locked  <= 1'b0;
    end
  end
endmodule

// File: rtl/dvfs_order_ctrl.sv
module dvfs_order_ctrl
  import dvfs_pkg::*;
#(
  parameter int LW = LVL_W,
  parameter int CW = VC_W,
  parameter logic [LW-1:0] BOOT_LEVEL = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [LW-1:0] req_level,
  input  logic          suspend_enter,
  input  logic          resume_exit,
  input  logic [LW-1:0] lock_level,
  output logic          busy,
  output logic          xfer_done,
  output logic          xfer_err,
  output logic [LW-1:0] cur_level,
  output logic          lock_active,
  output logic          vreg_req,
  output logic          vreg_sel,
  output logic [CW-1:0] vreg_code,
  input  logic          vreg_ack,
  output logic          div_start,
  output logic [LW-1:0] div_level,
  input  logic          div_done,
  output logic          pll_start,
  output logic          pll_full,
  output logic [LW-1:0] pll_level,
  input  logic          pll_done
);
  st_e           st_q;
  ph_e           ph_q;
  logic [LW-1:0] cur_q, tgt_q, org_q, saved_q;
  logic          up_q, full_q, err_q, req_q, vidx_q, lock_q;
  logic [1:0]    vcnt_q, ccnt_q;

  // named events
  logic          idle, take_susp, take_res, take_req, start, reject;
  logic          same_w, faster_w, relock_w, vack_w, cdone_w, release_w;
  logic [LW-1:0] nxt_tgt;

  assign idle      = (st_q == S_IDLE);
  assign take_susp = idle && suspend_enter && !lock_q;
  assign take_res  = idle && !suspend_enter && resume_exit && lock_q;
  assign take_req  = idle && !suspend_enter && !resume_exit && req_valid;
  assign start     = take_susp || take_res || take_req;
  assign nxt_tgt   = take_susp ? lock_level : (take_res ? saved_q : req_level);
  assign reject    = take_req && lock_q && (req_level != lock_level);
  assign vack_w    = req_q && vreg_ack;
  assign cdone_w   = (st_q == S_CA_WAIT && (up_q ? div_done : pll_done)) ||
                     (st_q == S_CB_WAIT && (up_q ? pll_done : div_done));
  assign release_w = (st_q == S_DONE) && (ph_q == PH_RES);

  dvfs_step_plan #(.LW(LW)) u_plan (
    .from_l(cur_q), .to_l(nxt_tgt),
    .same(same_w), .faster(faster_w), .relock(relock_w)
  );

  dvfs_lock_keeper #(.LW(LW)) u_lock (
    .clk(clk), .rst_n(rst_n), .engage(take_susp), .release_now(release_w),
    .cur_l(cur_q), .locked(lock_q), .saved_l(saved_q)
  );

  dvfs_volt_lut #(.LW(LW), .CW(CW)) u_lut (
    .level(tgt_q), .sel_int(vidx_q), .code(vreg_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ph_q   <= PH_REQ;
      cur_q  <= BOOT_LEVEL;
      tgt_q  <= BOOT_LEVEL;
      org_q  <= BOOT_LEVEL;
      up_q   <= 1'b0;
      full_q <= 1'b0;
      err_q  <= 1'b0;
      req_q  <= 1'b0;
      vidx_q <= 1'b0;
      vcnt_q <= '0;
      ccnt_q <= '0;
    end else begin
      if (vack_w) vcnt_q <= vcnt_q + 2'd1;
      if (cdone_w) ccnt_q <= ccnt_q + 2'd1;
      unique case (st_q)
        S_IDLE: if (start) begin
          tgt_q  <= nxt_tgt;
          org_q  <= cur_q;
          up_q   <= faster_w;
          full_q <= relock_w;
          err_q  <= reject;
          vidx_q <= 1'b0;
          vcnt_q <= '0;
          ccnt_q <= '0;
          ph_q   <= take_susp ? PH_SUSP : (take_res ? PH_RES : PH_REQ);
          st_q   <= (reject || same_w) ? S_DONE : (faster_w ? S_VUP : S_CA_GO);
        end
        S_VUP, S_VDN: begin
          if (vack_w) begin
            req_q  <= 1'b0;
            vidx_q <= !vidx_q;
            if (vidx_q) st_q <= (st_q == S_VUP) ? S_CA_GO : S_DONE;
          end else begin
            req_q <= 1'b1;
          end
        end
        S_CA_GO:   st_q <= S_CA_WAIT;
        S_CA_WAIT: if (cdone_w) st_q <= S_CB_GO;
        S_CB_GO:   st_q <= S_CB_WAIT;
        S_CB_WAIT: if (cdone_w) st_q <= up_q ? S_DONE : S_VDN;
        S_DONE: begin
          if (!err_q) cur_q <= tgt_q;
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy        = !idle;
  assign xfer_done   = (st_q == S_DONE);
  assign xfer_err    = (st_q == S_DONE) && err_q;
  assign cur_level   = cur_q;
  assign lock_active = lock_q;
  assign vreg_req    = req_q;
  assign vreg_sel    = vidx_q;
  assign div_start   = (st_q == S_CA_GO && up_q) || (st_q == S_CB_GO && !up_q);
  assign pll_start   = (st_q == S_CA_GO && !up_q) || (st_q == S_CB_GO && up_q);
  assign div_level   = tgt_q;
  assign pll_level   = tgt_q;
  assign pll_full    = full_q;

  p_volt_before_clk_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (div_start || pll_start) && up_q |-> vcnt_q == 2'd2);
  p_volt_after_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_req && !up_q |-> ccnt_q == 2'd2);
  p_pll_second_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pll_start && up_q |-> ccnt_q == 2'd1);
  p_div_second_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    div_start && !up_q |-> ccnt_q == 2'd1);
  p_relock_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pll_start && pll_full |-> (pll_level == '0 || org_q == '0));
  p_locked_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle && req_valid && !suspend_enter && !resume_exit && lock_active &&
    req_level != lock_level |=> xfer_done && xfer_err);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_req && !vreg_ack |=> vreg_req && $stable(vreg_code) && $stable(vreg_sel));
  p_one_action_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vreg_req, div_start, pll_start}));
endmodule

// File: tb/dvfs_order_ctrl_test.sv
module dvfs_order_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, suspend_enter = 1'b0, resume_exit = 1'b0;
  logic [1:0] req_level = '0, lock_level = 2'd3;
  logic busy, xfer_done, xfer_err, lock_active, vreg_req, vreg_sel;
  logic [1:0] cur_level, div_level, pll_level;
  logic [6:0] vreg_code;
  logic vreg_ack = 1'b0, div_done = 1'b0, pll_done = 1'b0;
  logic div_start, pll_start, pll_full;

  int n_tests = 0, n_fail = 0;
  int evq[$];
  int m_cur = 1, m_tgt = 1;
  bit prev_req = 1'b0;
  int rcnt = 0, dcnt = 0, pcnt = 0;
  int vcore[4] = '{120, 110, 100, 90};
  int vint[4]  = '{110, 110, 100, 100};

  always #2.5 clk = ~clk;

  dvfs_order_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .suspend_enter(suspend_enter), .resume_exit(resume_exit), .lock_level(lock_level),
    .busy(busy), .xfer_done(xfer_done), .xfer_err(xfer_err), .cur_level(cur_level),
    .lock_active(lock_active), .vreg_req(vreg_req), .vreg_sel(vreg_sel),
    .vreg_code(vreg_code), .vreg_ack(vreg_ack), .div_start(div_start),
    .div_level(div_level), .div_done(div_done), .pll_start(pll_start),
    .pll_full(pll_full), .pll_level(pll_level), .pll_done(pll_done)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // responders and event monitor (event codes: 1000+sel*200+code, 2000+lvl, 3000+full*10+lvl)
  always @(negedge clk) begin
    vreg_ack = 1'b0;
    div_done = 1'b0;
    pll_done = 1'b0;
    if (rst_n) begin
      if (vreg_req && !prev_req) evq.push_back(1000 + 200 * int'(vreg_sel) + int'(vreg_code));
      prev_req = vreg_req;
      if (div_start) begin evq.push_back(2000 + int'(div_level)); dcnt = 3; end
      else if (dcnt > 0) begin dcnt--; if (dcnt == 0) div_done = 1'b1; end
      if (pll_start) begin evq.push_back(3000 + 10 * int'(pll_full) + int'(pll_level)); pcnt = 4; end
      else if (pcnt > 0) begin pcnt--; if (pcnt == 0) pll_done = 1'b1; end
      if (vreg_req) begin
        rcnt++;
        if (rcnt == 3) begin vreg_ack = 1'b1; rcnt = 0; end
      end else rcnt = 0;
      // per-clock level model (R12)
      chk(int'(cur_level) == m_cur, "R12 cur_level per clock", int'(cur_level), m_cur);
      if (xfer_done && !xfer_err) m_cur = m_tgt;
    end
  end

  task automatic expect_events(input int o, input int t, input string tag);
    int exp[$];
    if (t < o) begin
      exp = '{1000 + vcore[t], 1200 + vint[t], 2000 + t, 3000 + ((t == 0) ? 10 : 0) + t};
    end else if (t > o) begin
      exp = '{3000 + ((o == 0) ? 10 : 0) + t, 2000 + t, 1000 + vcore[t], 1200 + vint[t]};
    end
    chk(evq.size() == exp.size(), {tag, " action count"}, evq.size(), exp.size());
    for (int i = 0; i < exp.size() && i < evq.size(); i++)
      chk(evq[i] == exp[i], {tag, " action order/value"}, evq[i], exp[i]);
    evq.delete();
  endtask

  task automatic wait_done(input bit exp_err, input string tag);
    int guard = 0;
    while (!xfer_done && guard < 300) begin @(negedge clk); guard++; end
    chk(xfer_done == 1'b1, {tag, " done seen"}, int'(xfer_done), 1);
    chk(xfer_err == exp_err, {tag, " error flag"}, int'(xfer_err), int'(exp_err));
    @(negedge clk);
  endtask

  task automatic do_req(input int lvl, input bit exp_err, input string tag);
    int o = m_cur;
    m_tgt = exp_err ? m_cur : lvl;
    req_valid = 1'b1;
    req_level = 2'(lvl);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(exp_err, tag);
    expect_events(o, exp_err ? o : lvl, tag);
  endtask

  task automatic quiet(input string tag);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!xfer_done && !busy, {tag, " no activity"}, int'(xfer_done | busy), 0);
    end
    chk(evq.size() == 0, {tag, " no actions"}, evq.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk(cur_level == 2'd1, "R11 boot level", int'(cur_level), 1);
    chk(!lock_active && !busy && !xfer_done, "R11 idle after reset",
        int'({lock_active, busy, xfer_done}), 0);
    // R6 same level
    do_req(1, 1'b0, "R6 same-level request");
    // R1 R3 R4 R5 faster into level 0: full relock
    do_req(0, 1'b0, "R1/R4 up to level 0");
    // R2 R3 R4 slower out of level 0: full relock
    do_req(2, 1'b0, "R2/R4 down from level 0");
    // R2 R5 slower, post-scaler only
    do_req(3, 1'b0, "R2/R5 down 2->3");
    // R1 R3 faster, post-scaler only
    do_req(1, 1'b0, "R1/R3 up 3->1");
    // R9 resume while unlocked is ignored
    resume_exit = 1'b1; @(negedge clk); resume_exit = 1'b0;
    quiet("R9 resume ignored");
    chk(!lock_active, "R9 still unlocked", int'(lock_active), 0);
    // R8 suspend: lock and move to lock_level 3
    m_tgt = 3;
    suspend_enter = 1'b1; @(negedge clk); suspend_enter = 1'b0;
    chk(lock_active, "R8 lock set", int'(lock_active), 1);
    wait_done(1'b0, "R8 suspend move");
    expect_events(1, 3, "R8 suspend move");
    // R7 locked: other level rejected, locked level fine
    do_req(0, 1'b1, "R7 reject while locked");
    chk(cur_level == 2'd3, "R7 level unchanged", int'(cur_level), 3);
    do_req(3, 1'b0, "R7 locked level accepted");
    // R8 suspend while locked ignored
    suspend_enter = 1'b1; @(negedge clk); suspend_enter = 1'b0;
    quiet("R8 second suspend ignored");
    // R9 resume: back to saved level 1 then unlock
    m_tgt = 1;
    resume_exit = 1'b1; @(negedge clk); resume_exit = 1'b0;
    wait_done(1'b0, "R9 resume move");
    expect_events(3, 1, "R9 resume move");
    chk(!lock_active, "R9 lock released", int'(lock_active), 0);
    chk(cur_level == 2'd1, "R9 saved level restored", int'(cur_level), 1);
    // after unlock, any level accepted
    do_req(0, 1'b0, "R7 unlocked request");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule